// File: doc/BRIEF.md
# Set-Associative Instruction Cache Controller

This block sits between an instruction fetch unit and a simple word-wide memory port. A fetch address arrives over a valid/ready handshake, and the block answers with one 32-bit instruction word. It looks the address up in an eight-way store of 128 sets with 32-byte lines. A hit answers on the next cycle. A miss first reads the whole line from memory and installs it in a victim way, then answers. A victim is an empty way if one exists, and otherwise the way picked by a tree pseudo-LRU per set.

Two controls act on the block from outside. An invalidate request names an address and empties every way of the set that address maps to. A cache-enable input, when low, turns each fetch into a single uncached memory read. Only one fetch is in flight at a time.

Top module: `icache_core`

## Requirements
- R1: Address bits [11:5] select one of 128 sets and bits [31:12] form the tag stored with each way; a line fill reads from the line base, the fetch address with bits [4:0] cleared.
- R2: When a valid way of the selected set holds the fetch tag, `resp_valid` pulses on the cycle after acceptance and no memory request is made. At most one way of a set matches at any time.
- R3: The returned word is word number addr[4:2] of the line, where word k sits at byte address line base + 4k.
- R4: On a miss, eight memory reads are issued at line base + 0, +4, … +28 in that order. Each request holds its address until `mem_ack`, which is a one-cycle pulse carrying `mem_rdata`. The response follows on the cycle after the eighth ack.
- R5: A completed fill writes the tag and line into the victim way and sets its valid bit, so a later fetch to that line hits.
- R6: The victim is the lowest-numbered invalid way of the set. When all eight ways are valid, the victim is found by walking a 7-bit tree from node 0: a bit of 0 goes to child 2n+1 and a bit of 1 goes to child 2n+2. The three bits read, most significant first, give the way.
- R7: Every hit and every fill updates the tree of its set. Along the path to the way used, each node is set to point away from that way: a node is written 1 when the way lies in its left half and 0 when it lies in its right half.
- R8: An accepted invalidate clears the valid bits of all eight ways in the set given by inval_addr[11:5]. While `inval_valid` is high in the idle state, `fetch_ready` is low, so the invalidate takes priority over a fetch.
- R9: A fetch accepted while `cache_en` is low causes exactly one memory read, at the fetch address with bits [1:0] cleared. That read data is returned, and no line is looked up or installed.
- R10: After reset every valid bit and every tree bit is 0, `fetch_ready` is high, `resp_valid` and `mem_req` are low, and the first fetch to any set misses.
- R11: `fetch_ready` stays low from acceptance of a miss or uncached fetch until its response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | High: cached fetches; low: uncached single reads |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Block accepts a fetch this cycle |
| fetch_addr | input | 32 | Byte address of the fetch |
| resp_valid | output | 1 | One-cycle pulse with the fetched word |
| resp_data | output | 32 | Fetched instruction word |
| inval_valid | input | 1 | Invalidate the set addressed by inval_addr |
| inval_addr | input | 32 | Address whose set is emptied |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word-aligned memory read address |
| mem_ack | input | 1 | Memory read done, data on mem_rdata |
| mem_rdata | input | 32 | Memory read data |

## Verification
Directed cases cover four situations:
- a cold fetch, which separates miss from hit and checks the fill order;
- a second word of the same line, which checks word selection;
- nine tags in one set, which shows whether eviction follows the tree rather than some other choice;
- memory contents changed behind the cache, which tells a cached answer from a fresh read and so exposes missing invalidation or unwanted allocation in uncached mode.

A random phase then draws fetches over four sets and twelve tags, mixed with uncached fetches, invalidates and contents changes. This puts constant pressure on replacement, so a wrong victim or a wrong tree update shows up as a mismatch between the expected and observed read count.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int SETS       = 128;
    localparam int WAYS       = 8;
    localparam int LINE_WORDS = 8;

    localparam int SET_W     = $clog2(SETS);
    localparam int WAY_W     = $clog2(WAYS);
    localparam int WORD_W    = $clog2(LINE_WORDS);
    localparam int BYTE_W    = $clog2(DATA_W / 8);
    localparam int WADDR_W   = ADDR_W - BYTE_W;
    localparam int TAG_W     = ADDR_W - SET_W - WORD_W - BYTE_W;
    localparam int LINE_BITS = DATA_W * LINE_WORDS;
    localparam int IDX_W     = SET_W + WAY_W;
    localparam int TREE_W    = WAYS - 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_BYPASS
    } ic_state_e;

    typedef struct packed {
        ic_state_e              st;
        logic [WADDR_W-1:0]     wa;
        logic [WAY_W-1:0]       way;
        logic [WORD_W-1:0]      cnt;
        logic [LINE_BITS-1:0]   fill_buf;
        logic                   rv;
        logic [DATA_W-1:0]      rdata;
    } ic_ctrl_s;
endpackage

// File: rtl/icache_store.sv
module icache_store
    import icache_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SET_W-1:0]     rd_set,
    input  logic [TAG_W-1:0]     rd_tag,
    output logic [WAYS-1:0]      rd_valid,
    output logic                 rd_hit,
    output logic [WAY_W-1:0]     rd_way,
    output logic [LINE_BITS-1:0] rd_line,
    input  logic                 wr_en,
    input  logic [SET_W-1:0]     wr_set,
    input  logic [WAY_W-1:0]     wr_way,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [LINE_BITS-1:0] wr_line,
    input  logic                 inv_en,
    input  logic [SET_W-1:0]     inv_set
);
    logic [TAG_W-1:0]     tag_mem  [SETS*WAYS];
    logic [LINE_BITS-1:0] line_mem [SETS*WAYS];
    logic [WAYS-1:0]      valid_q  [SETS];
    logic [WAYS-1:0]      match;

    assign rd_valid = valid_q[rd_set];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = valid_q[rd_set][w]
                              && (tag_mem[{rd_set, WAY_W'(w)}] == rd_tag);
        end
    endgenerate

    always_comb begin
        rd_hit = 1'b0;
        rd_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!rd_hit && match[w]) begin
                rd_hit = 1'b1;
                rd_way = WAY_W'(w);
            end
        end
    end

    assign rd_line = line_mem[{rd_set, rd_way}];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[{wr_set, wr_way}]  <= wr_tag;
            line_mem[{wr_set, wr_way}] <= wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (inv_en) begin
            valid_q[inv_set] <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R2

    AST_INV_CLEARS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> valid_q[$past(inv_set)] == '0); // R8

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inv_en) |=> valid_q[$past(wr_set)][$past(wr_way)]); // R5
endmodule

// File: rtl/icache_plru.sv
module icache_plru
    import icache_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] q_set,
    input  logic [WAYS-1:0]  q_valid,
    output logic [WAY_W-1:0] victim,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way
);
    logic [TREE_W-1:0] tree_q [SETS];
    logic [TREE_W-1:0] q_tree;
    logic [TREE_W-1:0] upd_tree_d;

    assign q_tree = tree_q[q_set];

    always_comb begin
        logic             found;
        logic             b;
        logic [WAY_W-1:0] node;
        found  = 1'b0;
        victim = '0;
        node   = '0;
        b      = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !q_valid[w]) begin
                found  = 1'b1;
                victim = WAY_W'(w);
            end
        end
        if (!found) begin
            for (int l = WAY_W - 1; l >= 0; l--) begin
                b         = q_tree[node];
                victim[l] = b;
                node      = {node[WAY_W-2:0], 1'b0} + WAY_W'(1) + WAY_W'(b);
            end
        end
    end

    always_comb begin
        logic             dir;
        logic [WAY_W-1:0] node;
        upd_tree_d = tree_q[upd_set];
        node       = '0;
        dir        = 1'b0;
        for (int l = WAY_W - 1; l >= 0; l--) begin
            dir              = upd_way[l];
            upd_tree_d[node] = ~dir;
            node             = {node[WAY_W-2:0], 1'b0} + WAY_W'(1) + WAY_W'(dir);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (upd_en) begin
            tree_q[upd_set] <= upd_tree_d;
        end
    end

    AST_ROOT_POINTS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> tree_q[$past(upd_set)][0] != $past(upd_way[WAY_W-1])); // R7
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cache_en,
    input  logic                 f_valid,
    output logic                 f_ready,
    input  logic [WADDR_W-1:0]   f_waddr,
    output logic                 r_valid,
    output logic [DATA_W-1:0]    r_data,
    input  logic                 inv_valid,
    input  logic [SET_W-1:0]     inv_set_in,
    output logic [SET_W-1:0]     look_set,
    output logic [TAG_W-1:0]     look_tag,
    input  logic                 hit,
    input  logic [WAY_W-1:0]     hit_way,
    input  logic [LINE_BITS-1:0] hit_line,
    input  logic [WAY_W-1:0]     victim,
    output logic                 line_we,
    output logic [SET_W-1:0]     line_set,
    output logic [WAY_W-1:0]     line_way,
    output logic [TAG_W-1:0]     line_tag,
    output logic [LINE_BITS-1:0] line_data,
    output logic                 inv_we,
    output logic [SET_W-1:0]     inv_set,
    output logic                 upd_en,
    output logic [SET_W-1:0]     upd_set,
    output logic [WAY_W-1:0]     upd_way,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [DATA_W-1:0]    mem_rdata
);
    ic_ctrl_s s_d, s_q;
    logic [LINE_BITS-1:0] fill_line;
    logic [WORD_W-1:0]    f_word;
    logic [WORD_W-1:0]    q_word;
    logic [SET_W-1:0]     q_set;

    assign look_set  = f_waddr[WORD_W +: SET_W];
    assign look_tag  = f_waddr[WADDR_W-1 -: TAG_W];
    assign f_word    = f_waddr[WORD_W-1:0];
    assign q_word    = s_q.wa[WORD_W-1:0];
    assign q_set     = s_q.wa[WORD_W +: SET_W];
    assign inv_set   = inv_set_in;
    assign line_set  = q_set;
    assign line_way  = s_q.way;
    assign line_tag  = s_q.wa[WADDR_W-1 -: TAG_W];
    assign line_data = fill_line;
    assign r_valid   = s_q.rv;
    assign r_data    = s_q.rdata;

    always_comb begin
        s_d       = s_q;
        s_d.rv    = 1'b0;
        f_ready   = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = '0;
        line_we   = 1'b0;
        inv_we    = 1'b0;
        upd_en    = 1'b0;
        upd_set   = q_set;
        upd_way   = s_q.way;
        fill_line = s_q.fill_buf;
        fill_line[s_q.cnt*DATA_W +: DATA_W] = mem_rdata;
        case (s_q.st)
            ST_IDLE: begin
                f_ready = !inv_valid;
                if (inv_valid) begin
                    inv_we = 1'b1;
                end else if (f_valid) begin
                    s_d.wa = f_waddr;
                    if (!cache_en) begin
                        s_d.st = ST_BYPASS;
                    end else if (hit) begin
                        s_d.rv    = 1'b1;
                        s_d.rdata = hit_line[f_word*DATA_W +: DATA_W];
                        upd_en    = 1'b1;
                        upd_set   = look_set;
                        upd_way   = hit_way;
                    end else begin
                        s_d.way = victim;
                        s_d.cnt = '0;
                        s_d.st  = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {s_q.wa[WADDR_W-1:WORD_W], s_q.cnt, BYTE_W'(0)};
                if (mem_ack) begin
                    s_d.fill_buf = fill_line;
                    if (s_q.cnt == '1) begin
                        line_we   = 1'b1;
                        upd_en    = 1'b1;
                        s_d.rv    = 1'b1;
                        s_d.rdata = fill_line[q_word*DATA_W +: DATA_W];
                        s_d.st    = ST_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + WORD_W'(1);
                    end
                end
            end
            ST_BYPASS: begin
                mem_req  = 1'b1;
                mem_addr = {s_q.wa, BYTE_W'(0)};
                if (mem_ack) begin
                    s_d.rv    = 1'b1;
                    s_d.rdata = mem_rdata;
                    s_d.st    = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FILL && mem_ack && s_q.cnt != '1)
            |=> mem_addr == $past(mem_addr) + ADDR_W'(DATA_W / 8)); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !f_ready); // R11

    AST_BYPASS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_BYPASS) |-> (!line_we && !upd_en)); // R9
endmodule

// File: rtl/icache_core.sv
module icache_core
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    input  logic              inval_valid,
    input  logic [ADDR_W-1:0] inval_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [SET_W-1:0]     look_set;
    logic [TAG_W-1:0]     look_tag;
    logic [WAYS-1:0]      rd_valid;
    logic                 hit;
    logic [WAY_W-1:0]     hit_way;
    logic [LINE_BITS-1:0] hit_line;
    logic [WAY_W-1:0]     victim;
    logic                 line_we;
    logic [SET_W-1:0]     line_set;
    logic [WAY_W-1:0]     line_way;
    logic [TAG_W-1:0]     line_tag;
    logic [LINE_BITS-1:0] line_data;
    logic                 inv_we;
    logic [SET_W-1:0]     inv_set;
    logic                 upd_en;
    logic [SET_W-1:0]     upd_set;
    logic [WAY_W-1:0]     upd_way;
    logic                 unused_low_bits;

    assign unused_low_bits = ^{fetch_addr[BYTE_W-1:0], inval_addr[ADDR_W-1:WORD_W+BYTE_W+SET_W],
                               inval_addr[WORD_W+BYTE_W-1:0]};

    icache_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cache_en   (cache_en),
        .f_valid    (fetch_valid),
        .f_ready    (fetch_ready),
        .f_waddr    (fetch_addr[ADDR_W-1:BYTE_W]),
        .r_valid    (resp_valid),
        .r_data     (resp_data),
        .inv_valid  (inval_valid),
        .inv_set_in (inval_addr[WORD_W+BYTE_W +: SET_W]),
        .look_set   (look_set),
        .look_tag   (look_tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .hit_line   (hit_line),
        .victim     (victim),
        .line_we    (line_we),
        .line_set   (line_set),
        .line_way   (line_way),
        .line_tag   (line_tag),
        .line_data  (line_data),
        .inv_we     (inv_we),
        .inv_set    (inv_set),
        .upd_en     (upd_en),
        .upd_set    (upd_set),
        .upd_way    (upd_way),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    icache_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (look_set),
        .rd_tag   (look_tag),
        .rd_valid (rd_valid),
        .rd_hit   (hit),
        .rd_way   (hit_way),
        .rd_line  (hit_line),
        .wr_en    (line_we),
        .wr_set   (line_set),
        .wr_way   (line_way),
        .wr_tag   (line_tag),
        .wr_line  (line_data),
        .inv_en   (inv_we),
        .inv_set  (inv_set)
    );

    icache_plru u_plru (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_set   (look_set),
        .q_valid (rd_valid),
        .victim  (victim),
        .upd_en  (upd_en),
        .upd_set (upd_set),
        .upd_way (upd_way)
    );
endmodule

// File: tb/icache_core_test.sv
module icache_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        fetch_valid = 1'b0;
    logic        fetch_ready;
    logic [31:0] fetch_addr = '0;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        inval_valid = 1'b0;
    logic [31:0] inval_addr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] salt = 32'h1357_9BDF;
    int          n_acks;
    logic [31:0] ack_log [16];

    logic [7:0]  m_valid [128];
    logic [19:0] m_tag   [128][8];
    logic [31:0] m_salt  [128][8];
    logic [6:0]  m_tree  [128];

    always #10 clk = ~clk;

    icache_core uut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .inval_valid(inval_valid), .inval_addr(inval_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mword(logic [31:0] a, logic [31:0] s);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ s;
    endfunction

    function automatic int m_victim(int s);
        int n = 0;
        int v = 0;
        for (int w = 0; w < 8; w++) if (!m_valid[s][w]) return w;
        for (int l = 0; l < 3; l++) begin
            int b = int'(m_tree[s][n]);
            v = v * 2 + b;
            n = 2 * n + 1 + b;
        end
        return v;
    endfunction

    function automatic void m_touch(int s, int w);
        int n = 0;
        for (int l = 0; l < 3; l++) begin
            int d = (w >> (2 - l)) & 1;
            m_tree[s][n] = (d == 0);
            n = 2 * n + 1 + d;
        end
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder: one-cycle ack per request word
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                mem_ack   = 1'b1;
                mem_rdata = mword(mem_addr, salt);
                if (n_acks < 16) ack_log[n_acks] = mem_addr;
                n_acks++;
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    task automatic do_fetch(logic [31:0] a, logic en, string kreq);
        int s = int'(a[11:5]);
        int hw = -1;
        int exp_acks;
        logic [31:0] exp_data;
        bit got = 0;
        int lat = 0;
        for (int w = 0; w < 8; w++)
            if (m_valid[s][w] && m_tag[s][w] == a[31:12]) hw = w;
        if (!en) begin
            exp_acks = 1;
            exp_data = mword(a, salt);
        end else if (hw >= 0) begin
            exp_acks = 0;
            exp_data = mword(a, m_salt[s][hw]);
            m_touch(s, hw);
        end else begin
            int v = m_victim(s);
            exp_acks = 8;
            exp_data = mword(a, salt);
            m_valid[s][v] = 1'b1;
            m_tag[s][v] = a[31:12];
            m_salt[s][v] = salt;
            m_touch(s, v);
        end
        @(negedge clk);
        n_acks = 0;
        cache_en = en;
        fetch_valid = 1'b1;
        fetch_addr = a;
        @(posedge clk);
        #1 fetch_valid = 1'b0;
        for (int i = 0; i < 100 && !got; i++) begin
            @(negedge clk);
            if (resp_valid) begin
                got = 1;
                lat = i;
            end else if (i == 0) begin
                chk("R11", "ready during fill", 32'(fetch_ready), 32'd0);
            end
        end
        chk("R4", "response seen", 32'(got), 32'd1);
        chk(kreq, "memory read count", 32'(n_acks), 32'(exp_acks));
        if (exp_acks == 0) chk("R2", "hit latency", 32'(lat), 32'd0);
        if (exp_acks == 8 && n_acks == 8)
            for (int k = 0; k < 8; k++)
                chk("R1", "fill address", ack_log[k], {a[31:5], 3'(k), 2'b00});
        if (exp_acks == 1 && n_acks == 1)
            chk("R9", "uncached address", ack_log[0], {a[31:2], 2'b00});
        chk("R3", "returned word", resp_data, exp_data);
    endtask

    task automatic do_inval(logic [31:0] a);
        @(negedge clk);
        inval_valid = 1'b1;
        inval_addr = a;
        #1 chk("R8", "ready while invalidating", 32'(fetch_ready), 32'd0);
        @(posedge clk);
        #1 inval_valid = 1'b0;
        m_valid[int'(a[11:5])] = '0;
    endtask

    function automatic logic [31:0] mk(int tag, int set, int word);
        return {20'(tag), 7'(set), 3'(word), 2'b00};
    endfunction

    initial begin
        for (int s = 0; s < 128; s++) begin
            m_valid[s] = '0;
            m_tree[s] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: idle after reset
        chk("R10", "ready after reset", 32'(fetch_ready), 32'd1);
        chk("R10", "resp_valid after reset", 32'(resp_valid), 32'd0);
        chk("R10", "mem_req after reset", 32'(mem_req), 32'd0);

        // R10 R4 R5: cold miss, then R2 R3 hit on a different word of the line
        do_fetch(mk(32'h12, 5, 1), 1'b1, "R10");
        do_fetch(mk(32'h12, 5, 6), 1'b1, "R5");
        do_fetch(mk(32'h12, 5, 0), 1'b1, "R2");

        // R6 R7: fill all ways of set 5, touch a few, then evict
        for (int t = 1; t < 8; t++) do_fetch(mk(32'h12 + t * 16, 5, t), 1'b1, "R6");
        do_fetch(mk(32'h12 + 48, 5, 2), 1'b1, "R7");
        do_fetch(mk(32'h12, 5, 7), 1'b1, "R7");
        do_fetch(mk(32'h300, 5, 3), 1'b1, "R6");
        for (int t = 0; t < 8; t++) do_fetch(mk(32'h12 + t * 16, 5, 4), 1'b1, "R6");

        // R8: stale data stays until the whole set is invalidated
        salt = 32'hCAFE_0001;
        do_fetch(mk(32'h22, 5, 5), 1'b1, "R2");
        do_inval(mk(32'h7777, 5, 3));
        do_fetch(mk(32'h22, 5, 5), 1'b1, "R8");
        do_fetch(mk(32'h42, 5, 5), 1'b1, "R8");

        // R9: uncached read neither uses nor fills the cache
        salt = 32'hBEEF_0002;
        do_fetch(mk(32'h22, 5, 1), 1'b0, "R9");
        do_fetch(mk(32'h22, 5, 1), 1'b1, "R9");
        do_fetch(mk(32'h999, 9, 2), 1'b0, "R9");
        do_fetch(mk(32'h999, 9, 2), 1'b1, "R9");

        // random phase over a small footprint
        for (int it = 0; it < 2500; it++) begin
            int r = int'($urandom % 100);
            int st = int'($urandom % 4);
            int tg = 32'h40 + int'($urandom % 12) * 3;
            int wd = int'($urandom % 8);
            if (r < 3) do_inval(mk(tg, st, wd));
            else if (r < 5) salt = $urandom;
            else do_fetch(mk(tg, st, wd), (r >= 12), "R6");
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule